// File: doc/BRIEF.md
# Receive-Only SPI Request and Byte-Valid Engine

This engine runs the receive-only side of an SPI master. Software writes a byte count, and the engine then requests one byte-long clock frame at a time from the neighbouring serial shifter, with no transmit data. It collects the returned bytes into 32-bit words and pushes each word into the neighbouring receive FIFO. A down-counter shows how many bytes are still to arrive. With every push, a byte-valid value reports how many bytes of that entry carry data. For a final partial entry this is 1 to 3, and a status neighbour places it at bits 30:28 of its status word.

The configured frame width plays no part here, because every entry is packed to 32 bits. Bytes are packed first-received-most-significant. A partial entry therefore has its first byte at the top of its valid span and zeros above that span. The engine stops issuing frames while the FIFO is full and picks up again once space frees. A count written while a transfer is running is added to the outstanding count. When the outstanding count reaches zero, a one-cycle done pulse is raised. Software is expected to keep each request within four times the FIFO depth in bytes.

Top module: `rxo_request_engine`

## Requirements
- R1: After reset, `remaining` is 0, `bytes_valid` is 0, and `frame_go`, `fifo_push` and `rx_done` are low.
- R2: A `req_wr` pulse with a nonzero `req_bytes` raises `remaining` by that amount on the next cycle. A pulse with `req_bytes` = 0 leaves `remaining` at its value and starts no frame.
- R3: `remaining` drops by exactly one in the cycle after each `byte_vld`, when no request is added in the same cycle.
- R4: `frame_go` is a one-cycle pulse. It is raised only while `remaining` is nonzero and no earlier frame's byte is still outstanding, so exactly one byte is requested per frame.
- R5: Every four received bytes form one entry pushed with `bytes_valid` = 4. The first byte of the four is in bits 31:24 and the last in bits 7:0. The push is raised the cycle after the fourth `byte_vld`.
- R6: When the outstanding count reaches zero with n = 1 to 3 bytes collected, those bytes are pushed as one entry with `bytes_valid` = n. The first byte is at bits n*8-1:(n-1)*8, later bytes follow at lower positions, and all bits above n*8 are zero.
- R7: No `frame_go` is raised while `fifo_full` is high or while a push is in progress. Frames resume after `fifo_full` falls, and `fifo_push` is never raised while `fifo_full` is high.
- R8: A request written while bytes are outstanding adds to them. A final byte arriving in the same cycle as such a write does not close a partial entry; that entry keeps filling.
- R9: `rx_done` is high for exactly one cycle. That cycle is the cycle of the push that brings the outstanding count to zero.
- R10: `remaining` saturates at 65535 when an added request would carry it past the counter's range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_wr | input | 1 | One-cycle write strobe for a receive request |
| req_bytes | input | 16 | Byte count added on `req_wr` |
| fifo_full | input | 1 | Receive FIFO has no free entry |
| frame_go | output | 1 | Request one byte-long clock frame from the shifter |
| byte_vld | input | 1 | Shifter returns the byte of the current frame |
| byte_data | input | 8 | Received byte, valid with `byte_vld` |
| fifo_push | output | 1 | Write `fifo_wdata` into the receive FIFO |
| fifo_wdata | output | 32 | Packed receive entry |
| bytes_valid | output | 3 | Valid-byte count of the last pushed entry |
| remaining | output | 16 | Bytes still to be received |
| rx_done | output | 1 | One-cycle pulse when the outstanding count reaches zero |

## Verification
The bench builds the engine with its default parameters: a 16-bit counter, 8-bit bytes and 4-byte entries. With these values, two writes are enough to reach the 65535 saturation point. Around the engine, the bench models a FIFO only two entries deep, so the full-FIFO pause is reached after eight bytes. It also models a shifter whose byte latency is switched between one and three cycles, which covers both back-to-back frames and frames separated by several idle cycles.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

  // Outstanding-count update: add a request, take one arrived byte, clip at cap.
  function automatic logic [31:0] rxo_next_count(input logic [31:0] cur,
                                                 input logic [31:0] add,
                                                 input logic        take,
                                                 input logic [31:0] cap);
    logic [32:0] sum;
    sum = {1'b0, cur} + {1'b0, add} - 33'(take);
    if (sum > {1'b0, cap}) return cap;
    return sum[31:0];
  endfunction

  // A byte closes the transfer only if it is the last one and nothing is added.
  function automatic logic rxo_is_final(input logic [31:0] cur,
                                        input logic        take,
                                        input logic [31:0] add);
    return take && (cur == 32'd1) && (add == 32'd0);
  endfunction

endpackage

// File: rtl/rxo_req_counter.sv
module rxo_req_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [CNT_W-1:0] req_bytes,
  input  logic             byte_vld,
  output logic [CNT_W-1:0] remaining,
  output logic             final_byte,
  output logic             rx_done
);
  import rxo_pkg::*;

  localparam logic [31:0] CAP = 32'((64'd1 << CNT_W) - 64'd1);

  logic [CNT_W-1:0] rem_q;
  logic [31:0]      add32;

  assign add32      = req_wr ? 32'(req_bytes) : 32'd0;
  assign final_byte = rxo_is_final(32'(rem_q), byte_vld, add32);
  assign remaining  = rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      rx_done <= 1'b0;
    end else begin
      rem_q   <= CNT_W'(rxo_next_count(32'(rem_q), add32, byte_vld, CAP));
      rx_done <= final_byte;
    end
  end

  // R9: the done pulse never lasts two cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R10: a nonzero add at the cap keeps the count at the cap
  a_r10_hold_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_bytes != '0 && 32'(rem_q) == CAP) |=> (32'(rem_q) == CAP));

endmodule

// File: rtl/rxo_frame_seq.sv
module rxo_frame_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic work_left,
  input  logic fifo_full,
  input  logic push_busy,
  input  logic byte_vld,
  output logic frame_go,
  output logic in_flight
);

  assign frame_go = !in_flight && work_left && !fifo_full && !push_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_flight <= 1'b0;
    else if (frame_go) in_flight <= 1'b1;
    else if (byte_vld) in_flight <= 1'b0;
  end

  // R4: a returned byte always belongs to an open frame
  a_r4_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> in_flight);

  // R4: frames are never requested back to back
  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |=> !frame_go);

endmodule

// File: rtl/rxo_packer.sv
module rxo_packer #(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               byte_vld,
  input  logic [BYTE_W-1:0]                  byte_data,
  input  logic                               final_byte,
  output logic                               fifo_push,
  output logic [WORD_BYTES*BYTE_W-1:0]       fifo_wdata,
  output logic [$clog2(WORD_BYTES+1)-1:0]    bytes_valid
);
  localparam int WORD_W = WORD_BYTES * BYTE_W;
  localparam int BV_W   = $clog2(WORD_BYTES + 1);
  localparam logic [BV_W-1:0] FULL_FILL = BV_W'(WORD_BYTES);

  logic [BV_W-1:0]   fill_q, fill_nx;
  logic [WORD_W-1:0] pack_q, merged;
  logic              word_done;

  generate
    if (WORD_BYTES == 1) begin : g_single
      assign merged = byte_data;
    end else begin : g_shift
      assign merged = (fill_q == '0) ? {{(WORD_W-BYTE_W){1'b0}}, byte_data}
                                     : {pack_q[WORD_W-BYTE_W-1:0], byte_data};
    end
  endgenerate

  assign fill_nx   = fill_q + 1'b1;
  assign word_done = byte_vld && ((fill_nx == FULL_FILL) || final_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q      <= '0;
      pack_q      <= '0;
      fifo_push   <= 1'b0;
      fifo_wdata  <= '0;
      bytes_valid <= '0;
    end else begin
      fifo_push <= 1'b0;
      if (word_done) begin
        fifo_push   <= 1'b1;
        fifo_wdata  <= merged;
        bytes_valid <= fill_nx;
        fill_q      <= '0;
        pack_q      <= '0;
      end else if (byte_vld) begin
        pack_q <= merged;
        fill_q <= fill_nx;
      end
    end
  end

  // R5: a pushed entry reports between one and a full word of bytes
  a_r5_bv_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (bytes_valid != '0 && bytes_valid <= FULL_FILL));

  // R6: bits above the valid span of a partial entry are zero
  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push && bytes_valid < FULL_FILL) |->
      ((fifo_wdata >> (32'(bytes_valid) * BYTE_W)) == '0));

  // R5: pushes are separated, one frame per byte takes at least two cycles
  a_r5_push_gap: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |=> !fifo_push);

endmodule

// File: rtl/rxo_request_engine.sv
module rxo_request_engine #(
  parameter int CNT_W      = 16,
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_wr,
  input  logic [CNT_W-1:0]                req_bytes,
  input  logic                            fifo_full,
  output logic                            frame_go,
  input  logic                            byte_vld,
  input  logic [BYTE_W-1:0]               byte_data,
  output logic                            fifo_push,
  output logic [WORD_BYTES*BYTE_W-1:0]    fifo_wdata,
  output logic [$clog2(WORD_BYTES+1)-1:0] bytes_valid,
  output logic [CNT_W-1:0]                remaining,
  output logic                            rx_done
);
  localparam int BV_W = $clog2(WORD_BYTES + 1);

  logic final_byte;
  logic in_flight;
  logic work_left;

  assign work_left = (remaining != '0);

  rxo_req_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_wr     (req_wr),
    .req_bytes  (req_bytes),
    .byte_vld   (byte_vld),
    .remaining  (remaining),
    .final_byte (final_byte),
    .rx_done    (rx_done)
  );

  rxo_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .work_left (work_left),
    .fifo_full (fifo_full),
    .push_busy (fifo_push),
    .byte_vld  (byte_vld),
    .frame_go  (frame_go),
    .in_flight (in_flight)
  );

  rxo_packer #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (byte_vld),
    .byte_data   (byte_data),
    .final_byte  (final_byte),
    .fifo_push   (fifo_push),
    .fifo_wdata  (fifo_wdata),
    .bytes_valid (bytes_valid)
  );

  // R7: the FIFO is never written while it reports full
  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);

  // R9: done coincides with the closing push and an empty count
  a_r9_done_with_push: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (fifo_push && remaining == '0));

  // R5: every push that does not close the transfer is a whole word
  a_r5_whole_unless_final: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push && !rx_done) |-> (bytes_valid == BV_W'(WORD_BYTES)));

  // R4: no frame is requested while a byte is outstanding
  a_r4_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && !byte_vld) |-> !frame_go);

endmodule

// File: tb/rxo_request_engine_bench.sv
module rxo_request_engine_bench;
  localparam int DEPTH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0;
  logic [15:0] req_bytes = '0;
  logic        fifo_full = 1'b0;
  logic        frame_go;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        fifo_push;
  logic [31:0] fifo_wdata;
  logic [2:0]  bytes_valid;
  logic [15:0] remaining;
  logic        rx_done;

  int total = 0;
  int bad   = 0;

  // reference model state
  int          m_rem, m_cnt, m_bv, f_cnt, ser_wait, lat;
  bit          m_inflight, m_push, m_done, m_go, pop_en, chk_on;
  logic [31:0] m_word, m_pdata;
  logic [7:0]  nb;
  int          add_v, done_cnt;
  logic [31:0] q_data[$];
  int          q_bv[$];

  always #5 clk = ~clk;

  rxo_request_engine u_rxo_request_engine (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_bytes(req_bytes),
    .fifo_full(fifo_full), .frame_go(frame_go), .byte_vld(byte_vld),
    .byte_data(byte_data), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
    .bytes_valid(bytes_valid), .remaining(remaining), .rx_done(rx_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model step on the edge, inputs are stable here
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem = 0; m_cnt = 0; m_bv = 0; m_inflight = 0; m_push = 0;
      m_done = 0; m_word = 0; m_pdata = 0; f_cnt = 0; ser_wait = 0;
    end else begin
      m_go = !m_inflight && m_rem != 0 && !fifo_full && !m_push;
      if (pop_en && f_cnt > 0) f_cnt--;
      if (m_push) f_cnt++;
      if (m_go) ser_wait = lat;
      add_v  = req_wr ? int'(req_bytes) : 0;
      m_push = 0;
      m_done = 0;
      if (byte_vld) begin
        m_word = (m_cnt == 0) ? {24'h0, byte_data} : {m_word[23:0], byte_data};
        m_cnt++;
        if (m_cnt == 4 || (m_rem == 1 && add_v == 0)) begin
          m_push  = 1;
          m_pdata = m_word;
          m_bv    = m_cnt;
          m_done  = (m_rem == 1 && add_v == 0);
          m_cnt   = 0;
        end
        m_rem--;
      end
      m_rem += add_v;
      if (m_rem > 65535) m_rem = 65535;
      if (m_go) m_inflight = 1;
      else if (byte_vld) m_inflight = 0;
    end
  end

  // neighbour models drive away from the edge, then compare every cycle
  always @(negedge clk) begin
    fifo_full = (f_cnt >= DEPTH);
    byte_vld  = 1'b0;
    if (ser_wait > 0) begin
      ser_wait--;
      if (ser_wait == 0) begin
        byte_vld  = 1'b1;
        byte_data = nb;
        nb        = nb + 8'd1;
      end
    end
    #1;
    if (rst_n && chk_on) begin
      chk(frame_go == (!m_inflight && m_rem != 0 && !fifo_full && !m_push),
          "R4/R7 frame_go", 32'(frame_go),
          32'(!m_inflight && m_rem != 0 && !fifo_full && !m_push));
      chk(remaining == 16'(m_rem), "R3 remaining", 32'(remaining), 32'(m_rem));
      chk(fifo_push == m_push, "R5 fifo_push", 32'(fifo_push), 32'(m_push));
      if (m_push) chk(fifo_wdata == m_pdata, "R5/R6 fifo_wdata", fifo_wdata, m_pdata);
      chk(bytes_valid == 3'(m_bv), "R6 bytes_valid", 32'(bytes_valid), 32'(m_bv));
      chk(rx_done == m_done, "R9 rx_done", 32'(rx_done), 32'(m_done));
      if (fifo_push) begin
        q_data.push_back(fifo_wdata);
        q_bv.push_back(int'(bytes_valid));
      end
      if (rx_done) done_cnt++;
    end
  end

  task automatic request(input int n);
    @(negedge clk);
    req_wr    = 1'b1;
    req_bytes = 16'(n);
    @(negedge clk);
    req_wr    = 1'b0;
    req_bytes = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (remaining == 16'd0 && ser_wait == 0 && !m_push) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(remaining == 16'd0, "R1 remaining", 32'(remaining), 0);
    chk(bytes_valid == 3'd0, "R1 bytes_valid", 32'(bytes_valid), 0);
    chk(!frame_go && !fifo_push && !rx_done, "R1 strobes",
        {29'd0, frame_go, fifo_push, rx_done}, 0);
  endtask

  initial begin
    int base, dbase;
    lat = 1; pop_en = 1; chk_on = 1; nb = 8'h01; done_cnt = 0;
    do_reset();

    // R2: zero-byte request has no effect
    request(0);
    repeat (3) @(negedge clk);
    #2;
    chk(remaining == 16'd0 && !frame_go, "R2 zero request",
        {15'd0, frame_go, remaining}, 0);

    // R5 R6 R9: six bytes -> one whole and one two-byte entry
    base = q_data.size(); dbase = done_cnt;
    request(6);
    #2;
    chk(remaining == 16'd6, "R2 count loaded", 32'(remaining), 6);
    wait_idle();
    chk(q_data.size() == base + 2, "R5 entries for 6", q_data.size(), base + 2);
    if (q_data.size() == base + 2) begin
      chk(q_data[base] == 32'h01020304 && q_bv[base] == 4, "R5 whole entry",
          q_data[base], 32'h01020304);
      chk(q_data[base+1] == 32'h00000506 && q_bv[base+1] == 2, "R6 two-byte entry",
          q_data[base+1], 32'h00000506);
    end
    chk(done_cnt == dbase + 1, "R9 one done", done_cnt, dbase + 1);

    // R6: three-byte and one-byte partial entries, slower shifter
    lat = 3;
    base = q_data.size();
    request(3);
    wait_idle();
    request(1);
    wait_idle();
    chk(q_data.size() == base + 2, "R6 partial count", q_data.size(), base + 2);
    if (q_data.size() == base + 2) begin
      chk(q_data[base] == 32'h00070809 && q_bv[base] == 3, "R6 three-byte entry",
          q_data[base], 32'h00070809);
      chk(q_data[base+1] == 32'h0000000A && q_bv[base+1] == 1, "R6 one-byte entry",
          q_data[base+1], 32'h0000000A);
    end

    // R7: FIFO fills, engine pauses, then resumes
    pop_en = 0;
    base = q_data.size();
    request(16);
    repeat (120) @(negedge clk);
    #2;
    chk(remaining == 16'd8, "R7 paused remaining", 32'(remaining), 8);
    chk(!frame_go, "R7 no frame while full", 32'(frame_go), 0);
    pop_en = 1;
    wait_idle();
    chk(q_data.size() == base + 4, "R7 resumed entries", q_data.size(), base + 4);

    // R8: request added while busy -> one whole, one three-byte entry, one done
    lat = 1;
    base = q_data.size(); dbase = done_cnt;
    request(4);
    repeat (2) @(negedge clk);
    request(3);
    wait_idle();
    chk(q_data.size() == base + 2, "R8 merged entries", q_data.size(), base + 2);
    if (q_data.size() == base + 2)
      chk(q_bv[base] == 4 && q_bv[base+1] == 3, "R8 valid counts",
          32'(q_bv[base+1]), 3);
    chk(done_cnt == dbase + 1, "R8 single done", done_cnt, dbase + 1);

    // R10: saturation of the outstanding count
    request(16'hFFFF);
    request(32);
    #2;
    chk(remaining == 16'hFFFF, "R10 saturate", 32'(remaining), 32'hFFFF);
    chk_on = 0;
    do_reset();
    chk_on = 1;
    repeat (4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule